// File: doc/BRIEF.md
# Accumulator CPU Timing Control

This block is the control and datapath of a small single-accumulator processor. It works on 16-bit words and 12-bit addresses. Its state is a program counter, an address register, an instruction register, a data register, an accumulator, a carry flag, an indirect flag and a run flag. A 4-bit step counter is decoded into timing slots, and each slot fires a fixed set of register transfers. The block runs seven memory-reference instructions and a halt. Every other opcode-7 word passes through as a no-op.

The processor sits next to a synchronous word memory. The memory captures its address on a clock edge and returns the word one clock later. Because of that latency, the address for a read is steered one slot ahead of the slot that consumes the data. Writes happen on the edge that ends the slot in which `memWe` is high.

After reset the processor is idle. A pulse on `startReq` sets the run flag, and execution then begins at the current program counter. A halt word clears the run flag. A later start resumes at the word that follows the halt.

Top module: `acc_cpu_top`

## Requirements
- R1: Reset clears PC, AR, IR, DR, AC, the carry flag, the indirect flag, the run flag and the step counter. After reset `running` is 0, `memWe` is 0, `memAddr` is 0 and `carryOut` is 0.
- R2: While the run flag is clear, the step counter stays at 0 and no memory write occurs. A high `startReq` sets the run flag on the next edge.
- R3: Instruction word layout: bit 15 is the indirect bit, bits 14..12 are the opcode and bits 11..0 are the address. Slot 0 copies PC to AR. Slot 1 loads IR with the word at PC and increments PC. Slot 2 copies bit 15 to the indirect flag and bits 11..0 to AR. Every read address is driven to memory in the slot before the one that takes its data.
- R4: For opcodes 0..6 with the indirect bit set, slot 3 replaces AR with the low 12 bits of the word at AR. With the indirect bit clear, slot 3 leaves AR unchanged.
- R5: Opcode 0 (AND) sets AC to AC AND M[ea]. Opcode 1 (ADD) sets AC to the low 16 bits of AC + M[ea] and sets the carry flag, seen on `carryOut`, to the carry-out of that sum.
- R6: Opcode 2 (LDA) copies M[ea] to AC. Opcode 3 (STA) writes AC to M[ea].
- R7: Opcode 4 (BUN) sets PC to ea.
- R8: Opcode 5 (BSA) writes the current PC, which is the return address, to M[ea] and sets PC to ea+1.
- R9: Opcode 6 (ISZ) writes M[ea]+1 back to M[ea]. If that result is 0, PC is incremented once more, so the next word is skipped.
- R10: The word 0x7001 (opcode 7, indirect bit 0, bit 0 set) clears the run flag at the end of slot 3. Nothing runs after it until the next start, which continues at the following word.
- R11: Every instruction takes a fixed number of cycles from slot 0: AND, ADD, LDA and BSA take 6, STA and BUN take 5, ISZ takes 7, and opcode-7 words take 4. Memory writes happen only in slots 4 and 6.
- R12: An opcode-7 word other than a halt (for example 0x7800 or 0xF000) changes no register other than PC, IR, AR and the indirect flag, and writes no memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Sets the run flag |
| memRdata | input | 16 | Word returned by memory one clock after its address |
| memAddr | output | 12 | Memory address for reads and writes |
| memWdata | output | 16 | Word to write |
| memWe | output | 1 | Write enable for the current cycle |
| running | output | 1 | Run flag |
| carryOut | output | 1 | Carry flag set by ADD |

## Verification
The bench runs fixed-seed random programs of AND, ADD, LDA, STA and ISZ, with both direct and indirect operands. It checks both the resulting memory image and the cycle count against an instruction-level model, so an address steered one slot late would load stale operands and an extra slot would show up in the cycle count. Directed programs cover several corner cases: a subroutine call and an indirect return through the stored link, which catches a link written after the increment; an ISZ that wraps from 0xFFFF, which catches a skip taken on the wrong value; an ADD that carries out; and a halt followed by a restart, which catches a counter that keeps running or a restart that loses the PC.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [1:0] {
    ADDR_PC = 2'd0,
    ADDR_IR = 2'd1,
    ADDR_RD = 2'd2,
    ADDR_AR = 2'd3
  } addrSel_e;

  typedef enum logic [1:0] {
    WD_AC = 2'd0,
    WD_PC = 2'd1,
    WD_DR = 2'd2
  } wdSel_e;

  typedef struct packed {
    addrSel_e addrSel;
    wdSel_e   wdSel;
    logic     memWr;
    logic     arFromPc;
    logic     irLoad;
    logic     pcInc;
    logic     decodeLoad;
    logic     arFromMem;
    logic     drLoad;
    logic     acAnd;
    logic     acAdd;
    logic     acFromDr;
    logic     arInc;
    logic     pcFromAr;
    logic     drInc;
    logic     runClr;
  } strobe_t;

  localparam logic [2:0] OP_AND = 3'd0;
  localparam logic [2:0] OP_ADD = 3'd1;
  localparam logic [2:0] OP_LDA = 3'd2;
  localparam logic [2:0] OP_STA = 3'd3;
  localparam logic [2:0] OP_BUN = 3'd4;
  localparam logic [2:0] OP_BSA = 3'd5;
  localparam logic [2:0] OP_ISZ = 3'd6;
  localparam logic [2:0] OP_EXT = 3'd7;

endpackage

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int SC_W  = 4,
  parameter int SLOTS = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startReq,
  input  logic [2:0]      opcode,
  input  logic            indFlag,
  input  logic            irBit0,
  input  logic            drZero,
  output strobe_t         st,
  output logic            running,
  output logic [SC_W-1:0] stepCnt
);

  logic [SC_W-1:0]  sc;
  logic             runFlag;
  logic             scClr;
  logic [SLOTS-1:0] slot;

  // one decoded line per timing slot
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slot[g] = (sc == SC_W'(g));
  end

  always_comb begin
    st         = '0;
    st.addrSel = ADDR_AR;
    st.wdSel   = WD_AC;
    scClr      = 1'b0;
    if (runFlag) begin
      if (slot[0]) begin
        st.addrSel  = ADDR_PC;
        st.arFromPc = 1'b1;
      end
      if (slot[1]) begin
        st.irLoad = 1'b1;
        st.pcInc  = 1'b1;
      end
      if (slot[2]) begin
        st.decodeLoad = 1'b1;
        st.addrSel    = ADDR_IR;
      end
      if (slot[3]) begin
        if (opcode == OP_EXT) begin
          scClr = 1'b1;
          if (!indFlag && irBit0) st.runClr = 1'b1;
        end else if (indFlag) begin
          st.arFromMem = 1'b1;
          st.addrSel   = ADDR_RD;
        end
      end
      if (slot[4]) begin
        case (opcode)
          OP_AND, OP_ADD, OP_LDA, OP_ISZ: st.drLoad = 1'b1;
          OP_STA: begin
            st.memWr = 1'b1;
            st.wdSel = WD_AC;
            scClr    = 1'b1;
          end
          OP_BUN: begin
            st.pcFromAr = 1'b1;
            scClr       = 1'b1;
          end
          OP_BSA: begin
            st.memWr = 1'b1;
            st.wdSel = WD_PC;
            st.arInc = 1'b1;
          end
          default: scClr = 1'b1;
        endcase
      end
      if (slot[5]) begin
        case (opcode)
          OP_AND: begin st.acAnd = 1'b1; scClr = 1'b1; end
          OP_ADD: begin st.acAdd = 1'b1; scClr = 1'b1; end
          OP_LDA: begin st.acFromDr = 1'b1; scClr = 1'b1; end
          OP_BSA: begin st.pcFromAr = 1'b1; scClr = 1'b1; end
          OP_ISZ: st.drInc = 1'b1;
          default: scClr = 1'b1;
        endcase
      end
      if (slot[6]) begin
        scClr = 1'b1;
        if (opcode == OP_ISZ) begin
          st.memWr = 1'b1;
          st.wdSel = WD_DR;
          st.pcInc = drZero;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sc      <= '0;
      runFlag <= 1'b0;
    end else begin
      if (st.runClr)     runFlag <= 1'b0;
      else if (startReq) runFlag <= 1'b1;
      if (runFlag) sc <= scClr ? '0 : sc + SC_W'(1);
    end
  end

  assign running = runFlag;
  assign stepCnt = sc;

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_cpu_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              memWe,
  output logic [2:0]        opcode,
  output logic              indFlag,
  output logic              irBit0,
  output logic              drZero,
  output logic              carryOut,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] arOut
);

  localparam int IND_BIT = WORD_W - 1;
  localparam int OP_LSB  = ADDR_W;

  logic [ADDR_W-1:0] pc, ar;
  logic [WORD_W-1:0] ir, dr, ac;
  logic              eFlag, iFlag;
  logic [WORD_W:0]   sum;

  assign sum = {1'b0, ac} + {1'b0, dr};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc    <= '0;
      ar    <= '0;
      ir    <= '0;
      dr    <= '0;
      ac    <= '0;
      eFlag <= 1'b0;
      iFlag <= 1'b0;
    end else begin
      if (st.pcFromAr)   pc <= ar;
      else if (st.pcInc) pc <= pc + ADDR_W'(1);

      if (st.arFromPc)        ar <= pc;
      else if (st.decodeLoad) ar <= ir[ADDR_W-1:0];
      else if (st.arFromMem)  ar <= memRdata[ADDR_W-1:0];
      else if (st.arInc)      ar <= ar + ADDR_W'(1);

      if (st.irLoad)     ir    <= memRdata;
      if (st.decodeLoad) iFlag <= ir[IND_BIT];

      if (st.drLoad)     dr <= memRdata;
      else if (st.drInc) dr <= dr + WORD_W'(1);

      if (st.acAnd) ac <= ac & dr;
      else if (st.acAdd) begin
        ac    <= sum[WORD_W-1:0];
        eFlag <= sum[WORD_W];
      end else if (st.acFromDr) ac <= dr;
    end
  end

  // read address is steered one slot ahead of the consumer
  always_comb begin
    case (st.addrSel)
      ADDR_PC: memAddr = pc;
      ADDR_IR: memAddr = ir[ADDR_W-1:0];
      ADDR_RD: memAddr = memRdata[ADDR_W-1:0];
      default: memAddr = ar;
    endcase
    case (st.wdSel)
      WD_PC:   memWdata = WORD_W'(pc);
      WD_DR:   memWdata = dr;
      default: memWdata = ac;
    endcase
  end

  assign memWe    = st.memWr;
  assign opcode   = ir[IND_BIT-1:OP_LSB];
  assign indFlag  = iFlag;
  assign irBit0   = ir[0];
  assign drZero   = (dr == '0);
  assign carryOut = eFlag;
  assign pcOut    = pc;
  assign arOut    = ar;

endmodule

// File: rtl/acc_cpu_top.sv
module acc_cpu_top
  import acc_cpu_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12,
  parameter int SC_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              memWe,
  output logic              running,
  output logic              carryOut
);

  strobe_t           st;
  logic [2:0]        opcode;
  logic              indFlag, irBit0, drZero;
  logic [SC_W-1:0]   stepCnt;
  logic [ADDR_W-1:0] pcVal, arVal;

  acc_seq_ctrl #(.SC_W(SC_W), .SLOTS(7)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .opcode(opcode), .indFlag(indFlag), .irBit0(irBit0), .drZero(drZero),
    .st(st), .running(running), .stepCnt(stepCnt)
  );

  acc_datapath #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .opcode(opcode), .indFlag(indFlag), .irBit0(irBit0), .drZero(drZero),
    .carryOut(carryOut), .pcOut(pcVal), .arOut(arVal)
  );

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int ADDR_W = 12,
  parameter int SC_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic              running,
  input logic              memWe,
  input logic [SC_W-1:0]   stepCnt,
  input logic [2:0]        opcode,
  input logic              drZero,
  input logic [ADDR_W-1:0] pcVal,
  input logic [ADDR_W-1:0] arVal
);

  p_step_limit_r11: assert property (@(posedge clk) disable iff (!rstN)
    stepCnt <= SC_W'(6));

  p_write_slot_r11: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (stepCnt == SC_W'(4) || stepCnt == SC_W'(6)));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (stepCnt == '0 && !memWe));

  p_start_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> $past(startReq));

  p_branch_pc_r7: assert property (@(posedge clk) disable iff (!rstN)
    (running && stepCnt == SC_W'(4) && opcode == 3'd4) |=> pcVal == $past(arVal));

  p_skip_pc_r9: assert property (@(posedge clk) disable iff (!rstN)
    (running && stepCnt == SC_W'(6) && opcode == 3'd6 && drZero)
      |=> pcVal == $past(pcVal) + ADDR_W'(1));

endmodule

bind acc_cpu_top acc_cpu_chk #(.ADDR_W(ADDR_W), .SC_W(SC_W)) u_chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .running(running),
  .memWe(memWe), .stepCnt(stepCnt), .opcode(opcode), .drZero(drZero),
  .pcVal(pcVal), .arVal(arVal)
);

// File: tb/sim_acc_cpu_top.sv
module sim_acc_cpu_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [15:0] memRdata = '0;
  logic [11:0] memAddr;
  logic [15:0] memWdata;
  logic        memWe, running, carryOut;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  acc_cpu_top u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .running(running), .carryOut(carryOut)
  );

  logic [15:0] mem [0:1023];
  logic [15:0] gm  [0:1023];

  always @(posedge clk) begin
    if (memWe) mem[memAddr[9:0]] <= memWdata;
    memRdata <= mem[memAddr[9:0]];
  end

  logic [11:0] mPc;
  logic [15:0] mAc;
  logic        mE;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input bit ind, input logic [2:0] op,
                                     input logic [11:0] a);
    return {ind, op, a};
  endfunction

  // instruction-level model of the requirements
  task automatic modelRun(output int cyc);
    logic [15:0] w, v;
    logic [11:0] ea;
    logic [16:0] s;
    cyc = 0;
    for (int n = 0; n < 2000; n++) begin
      w = gm[mPc[9:0]];
      mPc = mPc + 12'd1;
      cyc += 4;
      if (w[14:12] == 3'd7) begin
        if (!w[15] && w[0]) break;
        continue;
      end
      ea = w[15] ? gm[w[9:0]][11:0] : w[11:0];
      case (w[14:12])
        3'd0: begin mAc = mAc & gm[ea[9:0]]; cyc += 2; end
        3'd1: begin s = {1'b0, mAc} + {1'b0, gm[ea[9:0]]}; mAc = s[15:0]; mE = s[16]; cyc += 2; end
        3'd2: begin mAc = gm[ea[9:0]]; cyc += 2; end
        3'd3: begin gm[ea[9:0]] = mAc; cyc += 1; end
        3'd4: begin mPc = ea; cyc += 1; end
        3'd5: begin gm[ea[9:0]] = {4'd0, mPc}; mPc = ea + 12'd1; cyc += 2; end
        default: begin
          v = gm[ea[9:0]] + 16'd1; gm[ea[9:0]] = v;
          if (v == 16'd0) mPc = mPc + 12'd1;
          cyc += 3;
        end
      endcase
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mPc = '0; mAc = '0; mE = 1'b0;
  endtask

  task automatic clearMem();
    for (int i = 0; i < 1024; i++) mem[i] = 16'd0;
  endtask

  task automatic syncModel();
    for (int i = 0; i < 1024; i++) gm[i] = mem[i];
  endtask

  task automatic runDut(output int cyc);
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    cyc = 0;
    while (running && cyc < 5000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic compareRun(input string tag, input int dCyc, input int mCyc);
    int bad;
    int badAt;
    bad = 0; badAt = 0;
    for (int i = 'h100; i < 'h140; i++)
      if (mem[i] !== gm[i] && bad == 0) begin bad = 1; badAt = i; end
    chk(bad == 0, tag, "memory image", longint'(mem[badAt]), longint'(gm[badAt]));
    chk(dCyc == mCyc, "R11", "cycle count", dCyc, mCyc);
    chk(carryOut === mE, "R5", "carry flag", carryOut, mE);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int dc, mc;
    logic [2:0] ops [5];
    ops[0] = 3'd0; ops[1] = 3'd1; ops[2] = 3'd2; ops[3] = 3'd3; ops[4] = 3'd6;
    void'($urandom(32'd4711));

    clearMem();
    doReset();
    @(negedge clk);
    chk(running === 1'b0, "R1", "running after reset", running, 0);
    chk(memWe === 1'b0, "R1", "memWe after reset", memWe, 0);
    chk(memAddr === 12'd0, "R1", "memAddr after reset", memAddr, 0);
    chk(carryOut === 1'b0, "R1", "carryOut after reset", carryOut, 0);

    // R2: idle without start
    mem[0] = mk(0, 3'd3, 12'h131);
    mem[1] = 16'h7001;
    mem[12'h131] = 16'h5A5A;
    repeat (10) @(negedge clk);
    chk(running === 1'b0, "R2", "idle stays stopped", running, 0);
    chk(mem[12'h131] === 16'h5A5A, "R2", "no write while idle", mem[12'h131], 16'h5A5A);

    // D1: BUN, BSA, indirect return (R4 R7 R8)
    clearMem();
    mem[0]       = mk(0, 3'd4, 12'h010);
    mem[12'h010] = mk(0, 3'd5, 12'h040);
    mem[12'h011] = mk(0, 3'd3, 12'h131);
    mem[12'h012] = 16'h7001;
    mem[12'h041] = mk(0, 3'd2, 12'h100);
    mem[12'h042] = mk(1, 3'd4, 12'h040);
    mem[12'h100] = 16'hBEEF;
    doReset(); syncModel(); modelRun(mc); runDut(dc);
    chk(mem[12'h040] === 16'h0011, "R8", "stored link", mem[12'h040], 16'h0011);
    chk(mem[12'h131] === 16'hBEEF, "R4", "indirect return then store", mem[12'h131], 16'hBEEF);
    chk(dc == 31, "R7", "branch program cycles", dc, 31);
    compareRun("R7", dc, mc);

    // D2: ISZ wrap skips next word (R9)
    clearMem();
    mem[0] = mk(0, 3'd6, 12'h100);
    mem[1] = mk(0, 3'd3, 12'h131);
    mem[2] = 16'h7001;
    mem[12'h100] = 16'hFFFF;
    mem[12'h131] = 16'h1234;
    doReset(); syncModel(); modelRun(mc); runDut(dc);
    chk(mem[12'h100] === 16'h0000, "R9", "ISZ wrap value", mem[12'h100], 0);
    chk(mem[12'h131] === 16'h1234, "R9", "skipped store", mem[12'h131], 16'h1234);
    chk(dc == 11, "R11", "ISZ+halt cycles", dc, 11);

    // D2b: ISZ without skip
    clearMem();
    mem[0] = mk(1, 3'd6, 12'h120);
    mem[1] = mk(0, 3'd3, 12'h131);
    mem[2] = 16'h7001;
    mem[12'h120] = 16'h0105;
    mem[12'h105] = 16'h0004;
    mem[12'h131] = 16'h1234;
    doReset(); syncModel(); modelRun(mc); runDut(dc);
    chk(mem[12'h105] === 16'h0005, "R9", "ISZ indirect increment", mem[12'h105], 5);
    chk(mem[12'h131] === 16'h0000, "R6", "store not skipped", mem[12'h131], 0);

    // D3: halt, no-op words, resume (R10 R12)
    clearMem();
    mem[0] = 16'h7001;
    mem[1] = mk(0, 3'd2, 12'h100);
    mem[2] = 16'h7800;
    mem[3] = 16'hF000;
    mem[4] = mk(0, 3'd3, 12'h131);
    mem[5] = 16'h7001;
    mem[12'h100] = 16'h00C3;
    mem[12'h131] = 16'h7777;
    doReset(); syncModel(); modelRun(mc); runDut(dc);
    chk(dc == 4, "R10", "halt cycles", dc, 4);
    repeat (6) @(negedge clk);
    chk(running === 1'b0, "R10", "stays halted", running, 0);
    chk(mem[12'h131] === 16'h7777, "R10", "nothing after halt", mem[12'h131], 16'h7777);
    modelRun(mc); runDut(dc);
    chk(mem[12'h131] === 16'h00C3, "R12", "AC kept across no-op words", mem[12'h131], 16'h00C3);
    chk(dc == 6 + 4 + 4 + 5 + 4, "R12", "no-op word cycles", dc, 23);
    compareRun("R10", dc, mc);

    // D4: ADD carry-out (R5)
    clearMem();
    mem[0] = mk(0, 3'd2, 12'h100);
    mem[1] = mk(0, 3'd1, 12'h101);
    mem[2] = mk(0, 3'd3, 12'h131);
    mem[3] = 16'h7001;
    mem[12'h100] = 16'hFFFF;
    mem[12'h101] = 16'h0002;
    doReset(); syncModel(); modelRun(mc); runDut(dc);
    chk(carryOut === 1'b1, "R5", "ADD carry-out", carryOut, 1);
    chk(mem[12'h131] === 16'h0001, "R5", "ADD sum", mem[12'h131], 1);

    // random programs (R3 R4 R5 R6 R9 R11)
    for (int p = 0; p < 40; p++) begin
      int n;
      clearMem();
      n = 4 + int'($urandom % 12);
      for (int k = 0; k < 16; k++) begin
        case ($urandom % 4)
          0: mem['h100 + k] = 16'hFFFF;
          1: mem['h100 + k] = 16'h0000;
          default: mem['h100 + k] = 16'($urandom);
        endcase
        mem['h120 + k] = 16'h0100 + 16'(k);
      end
      for (int i = 0; i < n; i++) begin
        bit ind;
        int k;
        ind = 1'($urandom % 2);
        k = int'($urandom % 16);
        mem[i] = mk(ind, ops[$urandom % 5], ind ? 12'h120 + 12'(k) : 12'h100 + 12'(k));
      end
      mem[n]     = mk(0, 3'd3, 12'h130);
      mem[n + 1] = 16'h7001;
      mem[n + 2] = 16'h7001;
      doReset(); syncModel(); modelRun(mc); runDut(dc);
      compareRun("R3 R4 R6 R9", dc, mc);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule